// File: doc/BRIEF.md
# Sleep and wake-up event controller

This block decides when a processor core stops and when it starts again. The core raises a one-cycle wait-for-interrupt or wait-for-event request. It also raises a strobe when an exception handler returns to thread code. The controller moves to a normal or a deep low-power state and holds there until a wake condition is seen. On the way back it raises a single wake pulse. Clock gating, power switching and interrupt priority belong to other blocks, which act on the sleep, deep-sleep and wake outputs.

A one-bit event latch remembers an event that arrives while the core is not waiting for one. Events are an event-instruction pulse, an external event line and, when send-event-on-pend is set, the rising edge of any interrupt pending bit. The next wait-for-event finds the latch set, clears it and returns at once. A sleep can also start with no instruction at all: if sleep-on-exit is set, the handler-to-thread return starts one.

Top module: `slp_wake_ctrl`

## Requirements
- R1: After reset the state is running: sleep_o, deep_o and wake_o are 0, and the event latch is clear. The first wait-for-event after reset therefore sleeps.
- R2: A wfi_i pulse in the running state starts a sleep one cycle later. This holds only if no interrupt has both its pending and enable bits at 1. deep_o then equals deep_sel_i as sampled with the request (1 = deep, 0 = normal), and deep_o is never 1 without sleep_o.
- R3: A sleep started by wait-for-interrupt ends only when some interrupt has both its pending and enable bits at 1. The sleep outputs clear, and wake_o is 1, one cycle after that condition. Events and disabled pending interrupts do not end it.
- R4: A wfi_i pulse while an enabled interrupt is already pending causes no sleep and no wake pulse.
- R5: A sleep started by wait-for-event ends one cycle after a sev_i pulse, an ext_evt_i pulse or an enabled pending interrupt. Without one of these it stays asleep.
- R6: An event seen while no wait-for-event sleep is in progress sets the event latch. The next wfe_i clears the latch and does not sleep. A second wfe_i after that does sleep.
- R7: A wait-for-interrupt, and the sleep it starts, leave the event latch unchanged. A latched event survives such a sleep, and an event during such a sleep is latched.
- R8: With sev_on_pend_i at 1, a 0-to-1 change of any bit of irq_pend_i is an event, whatever irq_en_i holds. It wakes a wait-for-event sleep or is latched. With sev_on_pend_i at 0, the same change of a disabled interrupt is neither.
- R9: Only the rising edge of a pending bit is an event. A pending bit held at 1 does not wake a later wait-for-event sleep.
- R10: A ret_thread_i strobe with sleep_on_exit_i at 1 starts a sleep in the same way as wfi_i, with the same depth rule and the same wake rule. With sleep_on_exit_i at 0 the strobe has no effect.
- R11: wake_o is 1 for exactly one cycle for each return to the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wfi_i | input | 1 | Wait-for-interrupt request pulse |
| wfe_i | input | 1 | Wait-for-event request pulse |
| sev_i | input | 1 | Event instruction pulse |
| ext_evt_i | input | 1 | External event pulse |
| irq_pend_i | input | NumIrq | Per-interrupt pending bits |
| irq_en_i | input | NumIrq | Per-interrupt enable bits |
| ret_thread_i | input | 1 | Handler-to-thread return strobe |
| sleep_on_exit_i | input | 1 | Sleep on return to thread code |
| deep_sel_i | input | 1 | 1 selects deep sleep, 0 normal sleep |
| sev_on_pend_i | input | 1 | Any new pending interrupt counts as an event |
| sleep_o | output | 1 | Core is in a low-power state |
| deep_o | output | 1 | The low-power state is deep sleep |
| wake_o | output | 1 | One-cycle pulse on return to running |

## Verification
The event latch cannot be seen at the ports. Its content is brought out by the behaviour of the following wait-for-event: a latched event makes that request return with no sleep, while an empty latch makes it sleep. The hardest case keeps an event across a wait-for-interrupt sleep, and also covers an event that arrives during that sleep. The stimulus sets the latch, enters a wait-for-interrupt sleep, wakes it with an enabled interrupt and then issues two wait-for-event requests. The first request must return at once and the second must sleep. The pending-edge rule is checked the same way: after a disabled pending bit has woken the core and stays high, a new wait-for-event must still sleep.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DEEP  = 2'd2
  } slp_state_e;

endpackage

// File: rtl/slp_pend_edge.sv
module slp_pend_edge #(
  parameter int NumIrq = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NumIrq-1:0] pend_i,
  input  logic [NumIrq-1:0] en_i,
  output logic              rise_any_o,
  output logic              irq_wake_o
);

  logic [NumIrq-1:0] pend_q;
  logic [NumIrq-1:0] rise;
  logic [NumIrq-1:0] live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_i;
  end

  for (genvar g = 0; g < NumIrq; g++) begin : g_irq
    assign rise[g] = pend_i[g] & ~pend_q[g];
    assign live[g] = pend_i[g] & en_i[g];
  end

  assign rise_any_o = |rise;
  assign irq_wake_o = |live;

endmodule

// File: rtl/slp_evt_latch.sv
module slp_evt_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sev_i,
  input  logic ext_evt_i,
  input  logic pend_rise_i,
  input  logic sev_on_pend_i,
  input  logic consume_i,
  output logic evt_now_o,
  output logic latch_o
);

  logic latch_q;

  assign evt_now_o = sev_i | ext_evt_i | (sev_on_pend_i & pend_rise_i);

  // consume wins: an event seen together with the consuming request is used up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        latch_q <= 1'b0;
    else if (consume_i) latch_q <= 1'b0;
    else if (evt_now_o) latch_q <= 1'b1;
  end

  assign latch_o = latch_q;

endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wfi_i,
  input  logic wfe_i,
  input  logic exit_req_i,
  input  logic deep_sel_i,
  input  logic irq_wake_i,
  input  logic evt_now_i,
  input  logic latch_i,
  output logic consume_o,
  output logic sleep_o,
  output logic deep_o,
  output logic wake_o
);

  slp_state_e state_q, state_d;
  logic       wfe_mode_q, wfe_mode_d;
  logic       wake_q, wake_d;
  slp_state_e sleep_tgt;

  assign sleep_tgt = deep_sel_i ? ST_DEEP : ST_SLEEP;

  always_comb begin
    state_d    = state_q;
    wfe_mode_d = wfe_mode_q;
    wake_d     = 1'b0;
    consume_o  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (wfe_i) begin
          if (latch_i || evt_now_i) begin
            consume_o = 1'b1;
          end else if (!irq_wake_i) begin
            state_d    = sleep_tgt;
            wfe_mode_d = 1'b1;
          end
        end else if (wfi_i || exit_req_i) begin
          if (!irq_wake_i) begin
            state_d    = sleep_tgt;
            wfe_mode_d = 1'b0;
          end
        end
      end
      ST_SLEEP, ST_DEEP: begin
        if (irq_wake_i || (wfe_mode_q && evt_now_i)) begin
          state_d   = ST_RUN;
          wake_d    = 1'b1;
          consume_o = wfe_mode_q;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      wfe_mode_q <= 1'b0;
      wake_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      wfe_mode_q <= wfe_mode_d;
      wake_q     <= wake_d;
    end
  end

  assign sleep_o = (state_q != ST_RUN);
  assign deep_o  = (state_q == ST_DEEP);
  assign wake_o  = wake_q;

endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl #(
  parameter int NumIrq = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wfi_i,
  input  logic              wfe_i,
  input  logic              sev_i,
  input  logic              ext_evt_i,
  input  logic [NumIrq-1:0] irq_pend_i,
  input  logic [NumIrq-1:0] irq_en_i,
  input  logic              ret_thread_i,
  input  logic              sleep_on_exit_i,
  input  logic              deep_sel_i,
  input  logic              sev_on_pend_i,
  output logic              sleep_o,
  output logic              deep_o,
  output logic              wake_o
);

  logic pend_rise;
  logic irq_wake;
  logic evt_now;
  logic latch;
  logic consume;
  logic exit_req;

  assign exit_req = ret_thread_i & sleep_on_exit_i;

  slp_pend_edge #(.NumIrq(NumIrq)) i_pend_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (irq_pend_i),
    .en_i       (irq_en_i),
    .rise_any_o (pend_rise),
    .irq_wake_o (irq_wake)
  );

  slp_evt_latch i_evt_latch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sev_i         (sev_i),
    .ext_evt_i     (ext_evt_i),
    .pend_rise_i   (pend_rise),
    .sev_on_pend_i (sev_on_pend_i),
    .consume_i     (consume),
    .evt_now_o     (evt_now),
    .latch_o       (latch)
  );

  slp_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wfi_i      (wfi_i),
    .wfe_i      (wfe_i),
    .exit_req_i (exit_req),
    .deep_sel_i (deep_sel_i),
    .irq_wake_i (irq_wake),
    .evt_now_i  (evt_now),
    .latch_i    (latch),
    .consume_o  (consume),
    .sleep_o    (sleep_o),
    .deep_o     (deep_o),
    .wake_o     (wake_o)
  );

endmodule

// File: rtl/slp_wake_ctrl_chk.sv
module slp_wake_ctrl_chk #(
  parameter int NumIrq = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wfi_i,
  input logic              wfe_i,
  input logic              sev_i,
  input logic              ext_evt_i,
  input logic [NumIrq-1:0] irq_pend_i,
  input logic [NumIrq-1:0] irq_en_i,
  input logic              ret_thread_i,
  input logic              sleep_on_exit_i,
  input logic              deep_sel_i,
  input logic              sev_on_pend_i,
  input logic              sleep_o,
  input logic              deep_o,
  input logic              wake_o
);

  logic live_irq;
  assign live_irq = |(irq_pend_i & irq_en_i);

  p_deep_needs_sleep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep_o |-> sleep_o);

  p_wfi_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_o && wfi_i && !wfe_i && !live_irq) |=> (sleep_o && (deep_o == $past(deep_sel_i))));

  p_irq_wakes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && live_irq) |=> (wake_o && !sleep_o));

  p_no_spurious_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && !live_irq && !sev_i && !ext_evt_i && !sev_on_pend_i) |=> (sleep_o && !wake_o));

  p_exit_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_o && ret_thread_i && !sleep_on_exit_i && !wfi_i && !wfe_i) |=> !sleep_o);

  p_wake_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  p_wake_from_sleep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (!sleep_o && $past(sleep_o)));

endmodule

bind slp_wake_ctrl slp_wake_ctrl_chk #(.NumIrq(NumIrq)) i_chk (.*);

// File: tb/test_slp_wake_ctrl.sv
module test_slp_wake_ctrl;

  localparam int  NumIrq   = 8;
  localparam time ClkPeriod = 10ns;
  localparam int  WatchdogCycles = 2000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wfi = 0, wfe = 0, sev = 0, ext = 0, ret = 0;
  logic [NumIrq-1:0] pend = '0, en = '0;
  logic              soe = 0, dsel = 0, sop = 0;
  logic              sleep_s, deep_s, wake_s;

  typedef struct {
    logic  s;
    logic  d;
    logic  w;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #(ClkPeriod/2) clk = ~clk;

  slp_wake_ctrl #(.NumIrq(NumIrq)) i_slp_wake_ctrl (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .wfi_i           (wfi),
    .wfe_i           (wfe),
    .sev_i           (sev),
    .ext_evt_i       (ext),
    .irq_pend_i      (pend),
    .irq_en_i        (en),
    .ret_thread_i    (ret),
    .sleep_on_exit_i (soe),
    .deep_sel_i      (dsel),
    .sev_on_pend_i   (sop),
    .sleep_o         (sleep_s),
    .deep_o          (deep_s),
    .wake_o          (wake_s)
  );

  // monitor: one expected item per clock edge, compared after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if ({sleep_s, deep_s, wake_s} !== {e.s, e.d, e.w}) begin
        n_bad++;
        $display("FAIL %s: sleep/deep/wake actual %b%b%b expected %b%b%b",
                 e.tag, sleep_s, deep_s, wake_s, e.s, e.d, e.w);
      end
    end
  end

  // driver: inputs already set at a falling edge; push expectation, run one edge
  task automatic cyc(input string tag, input logic s, input logic d, input logic w);
    exp_t e;
    e.s = s; e.d = d; e.w = w; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    wfi = 0; wfe = 0; sev = 0; ext = 0; ret = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    if ({sleep_s, deep_s, wake_s} !== 3'b000) begin
      n_bad++;
      $display("FAIL R1: in reset actual %b%b%b expected 000", sleep_s, deep_s, wake_s);
    end
    n_vec++;
    rst_n = 1;
    cyc("R1", 0, 0, 0);

    // R1/R5: latch clear after reset, wfe sleeps; sev wakes
    wfe = 1;  cyc("R1 wfe after reset", 1, 0, 0);
    cyc("R5 stays asleep", 1, 0, 0);
    sev = 1;  cyc("R5 sev wake", 0, 0, 1);
    cyc("R11 wake single", 0, 0, 0);
    wfe = 1;  cyc("R5 wfe", 1, 0, 0);
    ext = 1;  cyc("R5 ext wake", 0, 0, 1);

    // R2/R3: deep wfi sleep, events and disabled irq ignored
    dsel = 1;
    wfi = 1;  cyc("R2 deep entry", 1, 1, 0);
    sev = 1;  cyc("R3 event no wake", 1, 1, 0);
    pend[2] = 1; cyc("R3 disabled no wake", 1, 1, 0);
    en[2] = 1;   cyc("R3 irq wake", 0, 0, 1);
    pend = '0; en = '0; dsel = 0;
    cyc("R11 wake single", 0, 0, 0);

    // R7: event during wfi sleep was latched
    wfe = 1;  cyc("R7 latched in wfi sleep", 0, 0, 0);
    wfe = 1;  cyc("R6 latch consumed", 1, 0, 0);
    sev = 1;  cyc("R5 sev wake", 0, 0, 1);

    // R6: event in run latched
    ext = 1;  cyc("R6 ext in run", 0, 0, 0);
    cyc("R6 idle", 0, 0, 0);
    wfe = 1;  cyc("R6 no sleep", 0, 0, 0);
    wfe = 1;  cyc("R6 second wfe sleeps", 1, 0, 0);
    sev = 1;  cyc("R6 wake", 0, 0, 1);

    // R4: wfi with enabled pending irq
    pend[0] = 1; en[0] = 1; cyc("R4 setup", 0, 0, 0);
    wfi = 1;  cyc("R4 no sleep", 0, 0, 0);
    pend = '0; en = '0; cyc("R4 clear", 0, 0, 0);

    // R7: latch survives wfi sleep
    ext = 1;  cyc("R7 latch set", 0, 0, 0);
    wfi = 1;  cyc("R7 wfi sleep", 1, 0, 0);
    pend[1] = 1; en[1] = 1; cyc("R7 irq wake", 0, 0, 1);
    pend = '0; en = '0; cyc("R7 clear", 0, 0, 0);
    wfe = 1;  cyc("R7 latch kept", 0, 0, 0);
    wfe = 1;  cyc("R7 then sleeps", 1, 0, 0);
    sev = 1;  cyc("R7 wake", 0, 0, 1);

    // R8/R9: send-event-on-pend
    sop = 1;
    wfe = 1;  cyc("R8 wfe", 1, 0, 0);
    pend[5] = 1; cyc("R8 disabled rise wakes", 0, 0, 1);
    wfe = 1;  cyc("R9 held pend no retrigger", 1, 0, 0);
    cyc("R9 still asleep", 1, 0, 0);
    pend[5] = 0; cyc("R9 fall no event", 1, 0, 0);
    sev = 1;  cyc("R9 wake", 0, 0, 1);
    sop = 0;
    wfe = 1;  cyc("R8 wfe", 1, 0, 0);
    pend[6] = 1; cyc("R8 off: rise ignored", 1, 0, 0);
    sev = 1;  cyc("R8 wake", 0, 0, 1);
    pend[6] = 0; cyc("R8 clear", 0, 0, 0);
    pend[7] = 1; cyc("R8 off: rise in run", 0, 0, 0);
    wfe = 1;  cyc("R8 off: not latched", 1, 0, 0);
    sev = 1;  cyc("R8 wake", 0, 0, 1);
    pend = '0; sop = 1;
    cyc("R8 clear", 0, 0, 0);
    pend[3] = 1; cyc("R8 rise in run", 0, 0, 0);
    wfe = 1;  cyc("R8 rise latched", 0, 0, 0);
    wfe = 1;  cyc("R8 then sleeps", 1, 0, 0);
    sev = 1;  cyc("R8 wake", 0, 0, 1);
    pend = '0; sop = 0;

    // R10: sleep on exit
    ret = 1;  cyc("R10 off: no effect", 0, 0, 0);
    soe = 1; dsel = 1;
    ret = 1;  cyc("R10 exit sleep deep", 1, 1, 0);
    ext = 1;  cyc("R10 event no wake", 1, 1, 0);
    pend[0] = 1; en[0] = 1; cyc("R10 irq wake", 0, 0, 1);
    pend = '0; en = '0; soe = 0; dsel = 0;
    cyc("R11 wake single", 0, 0, 0);

    @(negedge clk);
    done = 1;
  end

  initial begin
    int c;
    c = 0;
    while (!done && c < WatchdogCycles) begin
      @(posedge clk);
      c++;
    end
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule